// File: doc/BRIEF.md
# Word atomic read-modify-write sequencer

This block performs a single 32-bit atomic read-modify-write on a bus that splits each transfer into an address phase and a following data phase. An upstream stage presents an operation code, a word address and an operand, and holds them stable while `busy` is high. The block reads the target word with an exclusive read and combines it with the operand. It writes the new value back with an exclusive write. When the write completes it pulses `done` and returns the word it originally read on `result`.

An address with either of its two low bits set is never sent to the bus; it raises exception cause 6. Three conditions raise exception cause 7: a read that completes without exclusive-okay, a bus error on the read, or a bus error on the write. A fault parks the sequencer in a dedicated fault phase that holds `exc_valid` until the trap controller both enters the trap and signals ready. A trap entry that arrives from elsewhere while an operation is still in progress cancels that operation at once.

Top module: `amo_seq`

## Requirements
- R1: The value written is f(old, operand), where old is the word read and `req_op` selects f: 0 swap (operand), 1 add, 2 xor, 3 and, 4 or, 5 signed min, 6 signed max, 7 unsigned min, 8 unsigned max.
- R2: `done` is high for exactly the cycle in which the write data phase completes without error, and `result` then equals the word returned by the exclusive read.
- R3: A request whose `req_addr[1:0]` is not 00 drives no address phase. From the next cycle it holds `exc_valid` high with `exc_cause` = 6.
- R4: If the read data phase completes with `dph_exokay` low, no write transfer is issued and `exc_valid` rises with `exc_cause` = 7.
- R5: A `dph_err` on the read or on the write data phase gives `exc_valid` with `exc_cause` = 7, and `done` is not asserted for that request.
- R6: `trap_enter` outside the fault phase blocks any address phase in that cycle and returns the sequencer to idle on the next edge, so no later transfer of that request is issued.
- R7: In the fault phase `exc_valid` stays high until `trap_enter` and `trap_rdy` are both high in the same cycle; `trap_enter` alone does not release it.
- R8: After reset `busy`, `aph_valid`, `exc_valid` and `done` are low; `busy` is high whenever an operation is in progress or `req_valid` is high.
- R9: A transfer advances only on a handshake. While `aph_ready` is low, the read address phase stays presented with `aph_excl` high and `aph_write` low. Both the read and the write go to `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Atomic request present |
| req_op | input | 4 | Combining operation code |
| req_addr | input | AW | Word address |
| req_operand | input | DW | Source operand |
| busy | output | 1 | Upstream must hold the request |
| done | output | 1 | Operation completed |
| result | output | DW | Old memory value |
| aph_valid | output | 1 | Address phase request |
| aph_write | output | 1 | Address phase is a write |
| aph_excl | output | 1 | Exclusive access qualifier |
| aph_addr | output | AW | Transfer address |
| aph_wdata | output | DW | Write data |
| aph_ready | input | 1 | Address phase accepted |
| dph_ready | input | 1 | Data phase completes |
| dph_err | input | 1 | Data phase bus error |
| dph_exokay | input | 1 | Exclusive access succeeded |
| dph_rdata | input | DW | Read data |
| trap_enter | input | 1 | Trap entry from trap controller |
| trap_rdy | input | 1 | Trap controller ready |
| exc_valid | output | 1 | Exception raised |
| exc_cause | output | 4 | Exception cause code |

## Verification
A trap entry can land in the same cycle as the sequencer's own work. The bench provokes three such collisions. In the first, `trap_enter` arrives while the read data phase is completing; the bench judges that no write transfer follows and that `busy` falls. In the second, it arrives in the cycle the write address phase would be issued; the bench judges that `aph_valid` is low in that cycle. In the third, it meets the fault phase without `trap_rdy`; the bench judges that `exc_valid` and the cause survive until both handshake signals are high together.

// File: rtl/amo_seq.sv
module amo_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_operand,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          aph_valid,
  output logic          aph_write,
  output logic          aph_excl,
  output logic [AW-1:0] aph_addr,
  output logic [DW-1:0] aph_wdata,
  input  logic          aph_ready,
  input  logic          dph_ready,
  input  logic          dph_err,
  input  logic          dph_exokay,
  input  logic [DW-1:0] dph_rdata,
  input  logic          trap_enter,
  input  logic          trap_rdy,
  output logic          exc_valid,
  output logic [3:0]    exc_cause
);
  localparam logic [2:0] PH_IDLE = 3'd0, PH_RD = 3'd1, PH_CALC = 3'd2,
                         PH_WR = 3'd3, PH_FAULT = 3'd4;
  localparam logic [3:0] CAUSE_MISAL = 4'd6, CAUSE_ACCESS = 4'd7;

  logic [2:0]    phase;
  logic [DW-1:0] old_q, combined;

  wire misal = req_addr[1:0] != 2'b00;

  always_comb begin
    case (req_op)
      4'd1:    combined = old_q + req_operand;
      4'd2:    combined = old_q ^ req_operand;
      4'd3:    combined = old_q & req_operand;
      4'd4:    combined = old_q | req_operand;
      4'd5:    combined = ($signed(old_q) < $signed(req_operand)) ? old_q : req_operand;
      4'd6:    combined = ($signed(old_q) > $signed(req_operand)) ? old_q : req_operand;
      4'd7:    combined = (old_q < req_operand) ? old_q : req_operand;
      4'd8:    combined = (old_q > req_operand) ? old_q : req_operand;
      default: combined = req_operand;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      old_q <= '0;
    end else if (trap_enter && (phase != PH_FAULT || trap_rdy)) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:
          if (req_valid) begin
            if (misal)          phase <= PH_FAULT;
            else if (aph_ready) phase <= PH_RD;
          end
        PH_RD:
          if (dph_ready) begin
            if (dph_err || !dph_exokay) phase <= PH_FAULT;
            else begin
              old_q <= dph_rdata;
              phase <= PH_CALC;
            end
          end
        PH_CALC:
          if (aph_ready) phase <= PH_WR;
        PH_WR:
          if (dph_ready) phase <= dph_err ? PH_FAULT : PH_IDLE;
        PH_FAULT: phase <= PH_FAULT;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assign aph_valid = !trap_enter &&
                     ((phase == PH_IDLE && req_valid && !misal) || phase == PH_CALC);
  assign aph_write = phase == PH_CALC;
  assign aph_excl  = aph_valid;
  assign aph_addr  = req_addr;
  assign aph_wdata = combined;

  assign done      = phase == PH_WR && dph_ready && !dph_err && !trap_enter;
  assign result    = old_q;
  assign busy      = phase != PH_IDLE || req_valid;
  assign exc_valid = phase == PH_FAULT;
  assign exc_cause = !exc_valid ? 4'd0 : misal ? CAUSE_MISAL : CAUSE_ACCESS;
endmodule

// File: rtl/amo_seq_chk.sv
module amo_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] phase,
  input logic       req_valid,
  input logic [1:0] req_lo,
  input logic [1:0] aph_lo,
  input logic       aph_valid,
  input logic       dph_ready,
  input logic       dph_exokay,
  input logic       trap_enter,
  input logic       trap_rdy,
  input logic       busy,
  input logic       done,
  input logic       exc_valid,
  input logic [3:0] exc_cause
);
  assert_aligned_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    aph_valid |-> aph_lo == 2'b00);

  assert_misalign_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && req_valid && req_lo != 2'b00 && !trap_enter)
      |=> (exc_valid && exc_cause == 4'd6));

  assert_noexcl_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && dph_ready && !dph_exokay && !trap_enter) |=> phase == 3'd4);

  assert_trap_blocks_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |-> !aph_valid);

  assert_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter && phase != 3'd4) |=> phase == 3'd0);

  assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && !(trap_enter && trap_rdy)) |=> exc_valid);

  assert_fault_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && trap_enter && trap_rdy) |=> phase == 3'd0);

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 3'd0 |-> busy);

  assert_done_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !exc_valid);
endmodule

bind amo_seq amo_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .req_valid(req_valid),
  .req_lo(req_addr[1:0]), .aph_lo(aph_addr[1:0]), .aph_valid(aph_valid),
  .dph_ready(dph_ready), .dph_exokay(dph_exokay), .trap_enter(trap_enter),
  .trap_rdy(trap_rdy), .busy(busy), .done(done), .exc_valid(exc_valid),
  .exc_cause(exc_cause)
);

// File: tb/amo_seq_tb.sv
`timescale 1ns/1ps
module amo_seq_tb;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        req_valid = 0;
  logic [3:0]  req_op = 0;
  logic [31:0] req_addr = 0, req_operand = 0;
  logic        busy, done, aph_valid, aph_write, aph_excl, aph_ready;
  logic [31:0] result, aph_addr, aph_wdata, dph_rdata;
  logic        dph_ready, dph_err, dph_exokay;
  logic        trap_enter = 0, trap_rdy = 0;
  logic        exc_valid;
  logic [3:0]  exc_cause;

  logic        cfg_hold = 0, cfg_exokay = 1, cfg_err_rd = 0, cfg_err_wr = 0;
  logic [31:0] rd_word = 0;
  logic        pend, pend_wr;
  logic [31:0] pend_wdata, last_wr, pend_addr;
  int          n_rd, n_wr;
  int          n_chk = 0, n_fail = 0;

  amo_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_operand(req_operand), .busy(busy), .done(done),
    .result(result), .aph_valid(aph_valid), .aph_write(aph_write),
    .aph_excl(aph_excl), .aph_addr(aph_addr), .aph_wdata(aph_wdata),
    .aph_ready(aph_ready), .dph_ready(dph_ready), .dph_err(dph_err),
    .dph_exokay(dph_exokay), .dph_rdata(dph_rdata), .trap_enter(trap_enter),
    .trap_rdy(trap_rdy), .exc_valid(exc_valid), .exc_cause(exc_cause)
  );

  assign aph_ready  = !cfg_hold;
  assign dph_ready  = pend;
  assign dph_rdata  = rd_word;
  assign dph_exokay = cfg_exokay;
  assign dph_err    = pend && (pend_wr ? cfg_err_wr : cfg_err_rd);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 0; pend_wr <= 0; pend_wdata <= 0; pend_addr <= 0;
      last_wr <= 32'hDEAD_BEEF; n_rd <= 0; n_wr <= 0;
    end else begin
      if (pend && pend_wr && !cfg_err_wr) last_wr <= pend_wdata;
      if (aph_valid && aph_ready) begin
        pend <= 1; pend_wr <= aph_write; pend_wdata <= aph_wdata; pend_addr <= aph_addr;
        if (aph_write) n_wr <= n_wr + 1; else n_rd <= n_rd + 1;
      end else pend <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd1: return a + b;
      4'd2: return a ^ b;
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return ($signed(a) < $signed(b)) ? a : b;
      4'd6: return ($signed(a) > $signed(b)) ? a : b;
      4'd7: return (a < b) ? a : b;
      4'd8: return (a > b) ? a : b;
      default: return b;
    endcase
  endfunction

  task automatic start(input logic [3:0] op, input logic [31:0] addr, input logic [31:0] opnd);
    req_op = op; req_addr = addr; req_operand = opnd; req_valid = 1;
  endtask

  task automatic wait_end(output bit got_done, output bit got_exc, output logic [31:0] res);
    got_done = 0; got_exc = 0; res = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) begin got_done = 1; res = result; req_valid = 0; break; end
      if (exc_valid) begin got_exc = 1; break; end
    end
  endtask

  task automatic clear_fault(input string req);
    trap_enter = 1; trap_rdy = 1; req_valid = 0;
    @(negedge clk);
    trap_enter = 0; trap_rdy = 0;
    chk(!exc_valid && !busy, req, {31'd0, exc_valid}, 0);
  endtask

  task automatic t_op(input logic [3:0] op, input logic [31:0] mem, input logic [31:0] opnd);
    bit d, e; logic [31:0] r; int w0;
    rd_word = mem; w0 = n_wr;
    start(op, 32'h0000_1000, opnd);
    wait_end(d, e, r);
    chk(d && !e, "R2", {30'd0, e, d}, 1);
    chk(r == mem, "R2", r, mem);
    @(negedge clk);
    chk(last_wr == model(op, mem, opnd), "R1", last_wr, model(op, mem, opnd));
    chk(pend_addr == 32'h0000_1000 && n_wr == w0 + 1, "R9", pend_addr, 32'h1000);
    chk(!busy, "R8", {31'd0, busy}, 0);
  endtask

  task automatic t_misalign(input logic [1:0] off);
    int r0;
    r0 = n_rd;
    start(4'd1, 32'h0000_2000 | off, 32'd5);
    #1 chk(!aph_valid, "R3", {31'd0, aph_valid}, 0);
    @(negedge clk);
    chk(exc_valid && exc_cause == 4'd6, "R3", {28'd0, exc_cause}, 6);
    trap_enter = 1;
    @(negedge clk);
    trap_enter = 0;
    chk(exc_valid && exc_cause == 4'd6, "R7", {31'd0, exc_valid}, 1);
    chk(n_rd == r0, "R3", n_rd, r0);
    clear_fault("R7");
  endtask

  task automatic t_noexcl;
    bit d, e; logic [31:0] r; int w0;
    w0 = n_wr; cfg_exokay = 0;
    start(4'd0, 32'h0000_3000, 32'd9);
    wait_end(d, e, r);
    chk(e && !d && exc_cause == 4'd7, "R4", {28'd0, exc_cause}, 7);
    @(negedge clk);
    chk(n_wr == w0 && exc_valid, "R4", n_wr, w0);
    cfg_exokay = 1;
    clear_fault("R7");
  endtask

  task automatic t_err(input bit on_write);
    bit d, e; logic [31:0] r; logic [31:0] lw;
    lw = last_wr; rd_word = 32'h55;
    cfg_err_rd = !on_write; cfg_err_wr = on_write;
    start(4'd1, 32'h0000_4000, 32'd1);
    wait_end(d, e, r);
    chk(e && !d && exc_cause == 4'd7, "R5", {28'd0, exc_cause}, 7);
    @(negedge clk);
    chk(last_wr == lw, "R5", last_wr, lw);
    cfg_err_rd = 0; cfg_err_wr = 0;
    clear_fault("R5");
  endtask

  task automatic t_squash(input int delay);
    int w0;
    w0 = n_wr; rd_word = 32'h77;
    start(4'd1, 32'h0000_5000, 32'd1);
    repeat (delay) @(negedge clk);
    trap_enter = 1; req_valid = 0;
    #1 chk(!aph_valid, "R6", {31'd0, aph_valid}, 0);
    @(negedge clk);
    trap_enter = 0;
    chk(!busy && !exc_valid, "R6", {31'd0, busy}, 0);
    repeat (3) @(negedge clk);
    chk(n_wr == w0 && !aph_valid, "R6", n_wr, w0);
  endtask

  task automatic t_hold;
    bit d, e; logic [31:0] r; int r0;
    r0 = n_rd; cfg_hold = 1; rd_word = 32'h10;
    start(4'd4, 32'h0000_6000, 32'h01);
    repeat (3) @(negedge clk);
    chk(aph_valid && aph_excl && !aph_write && busy, "R9", {29'd0, aph_valid, aph_excl, aph_write}, 3'b110);
    chk(n_rd == r0, "R9", n_rd, r0);
    cfg_hold = 0;
    wait_end(d, e, r);
    chk(d && r == 32'h10, "R9", r, 32'h10);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !aph_valid && !exc_valid && !done, "R8",
        {28'd0, busy, aph_valid, exc_valid, done}, 0);
    for (int op = 0; op < 9; op++) t_op(op[3:0], 32'h8000_0005, 32'h0000_0007);
    for (int op = 0; op < 9; op++) t_op(op[3:0], 32'h0000_0010, 32'hFFFF_FFF0);
    for (int off = 1; off < 4; off++) t_misalign(off[1:0]);
    t_noexcl();
    t_err(0);
    t_err(1);
    t_squash(1);
    t_squash(2);
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule